// File: doc/BRIEF.md
# SDRAM Command Bus Protocol Monitor

This block sits beside an SDRAM command bus and watches it without driving anything. On every clock it turns the chip-select, row-strobe, column-strobe, write-enable and clock-enable levels into one command. It keeps a model of every bank, either idle or holding an open row, and follows mode-register loads, refreshes and self-refresh entry. When a command breaks an ordering rule it raises a one-cycle error pulse with a code, and it sets a sticky bit for that code.

It is meant for simulation and for on-chip debug next to a memory controller. The monitored bus is fed in directly. The outputs are the decoded command, the bank state and open rows, the captured mode word, a self-refresh flag, an auto-refresh count and the error signals. Every output is registered, so it shows the effect of the command sampled at the edge before it. The mode-load spacing (TMRD, in clocks) and the bank count are parameters.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A cycle with `cs_n` high decodes as inhibit (cmd_code 0) and changes no bank state, open row or mode word. With `cs_n` low, the {ras_n,cas_n,we_n} levels decode as: 111 no-op (1), 011 activate (2), 101 read (3), 100 write (4), 110 burst stop (5), 010 precharge (6), 001 refresh, 000 mode load (9). Refresh decodes as code 7 when `cke` is high and code 8 when `cke` is low.
- R2: An activate marks the bank selected by `ba` as active and stores `addr` as that bank's open row.
- R3: A precharge with `addr[10]` high returns every bank to idle whatever `ba` holds. With `addr[10]` low it returns only bank `ba` to idle.
- R4: A read or write with `addr[10]` high returns its bank to idle BL clocks after the command edge. Mode bits [2:0] set BL: 0→1, 1→2, 2→4, 3→8, other values →1. When mode bit 9 is set, a write uses BL 1.
- R5: A mode load copies `addr` into `mode_reg`. A mode load while any bank is active is flagged with error code 1.
- R6: Any command other than inhibit or no-op that arrives fewer than TMRD clocks after a mode load is flagged with code 2. This code takes priority over all other codes.
- R7: A read or write to an idle bank is flagged with code 3.
- R8: An activate to an already active bank is flagged with code 4.
- R9: A refresh (auto or self) issued while any bank is active is flagged with code 5. An auto refresh increments `ref_count`. Self-refresh entry sets `self_refresh`, which clears on the first later edge where `cke` is high.
- R10: `err_pulse` is high for exactly the one cycle after an offending command's edge, with `err_code` set to its code. Otherwise `err_code` is 0. `err_seen` bit k-1 is set for every code k seen and clears only on reset.
- R11: After reset, all banks are idle and the open rows, `mode_reg`, `cmd_code`, `ref_count`, `self_refresh`, `err_pulse`, `err_code` and `err_seen` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| cke | input | 1 | Monitored clock enable |
| cs_n | input | 1 | Monitored chip select, active low |
| ras_n | input | 1 | Monitored row strobe, active low |
| cas_n | input | 1 | Monitored column strobe, active low |
| we_n | input | 1 | Monitored write enable, active low |
| ba | input | BW | Monitored bank address |
| addr | input | AW | Monitored address bus |
| cmd_code | output | 4 | Last decoded command |
| bank_active | output | NB | One bit per bank, 1 = row open |
| open_row | output | NB*AW | Open row of each bank, bank b at [b*AW +: AW] |
| mode_reg | output | AW | Last loaded mode word |
| self_refresh | output | 1 | Self-refresh entered and clock enable still low |
| ref_count | output | RCW | Count of auto refreshes |
| err_pulse | output | 1 | One-cycle violation pulse |
| err_code | output | 3 | Code of the violation, 0 when none |
| err_seen | output | 5 | Sticky bit per error code |

## Verification
The assertions assume the bus holds known levels on every sampled edge, and that `ba` always selects an existing bank. They also assume the precharge-all bit is the only address bit that widens a precharge. The directed stimulus changes pins only at the falling edge and keeps every bank index inside the parameterised count. It reaches each error on purpose, including a mode load issued against an open bank and a command issued inside the mode-load window. In between, it keeps legal traffic spaced so that each error case is triggered by exactly one command.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int NB     = 4,
  parameter int AW     = 12,
  parameter int TMRD   = 2,
  parameter int RCW    = 16,
  parameter int AP_BIT = 10,
  localparam int BW    = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BW-1:0]    ba,
  input  logic [AW-1:0]    addr,
  output logic [3:0]       cmd_code,
  output logic [NB-1:0]    bank_active,
  output logic [NB*AW-1:0] open_row,
  output logic [AW-1:0]    mode_reg,
  output logic             self_refresh,
  output logic [RCW-1:0]   ref_count,
  output logic             err_pulse,
  output logic [2:0]       err_code,
  output logic [4:0]       err_seen
);

  localparam int MW = (TMRD > 1) ? $clog2(TMRD) + 1 : 1;

  localparam logic [3:0] C_INH  = 4'd0;
  localparam logic [3:0] C_NOP  = 4'd1;
  localparam logic [3:0] C_ACT  = 4'd2;
  localparam logic [3:0] C_RD   = 4'd3;
  localparam logic [3:0] C_WR   = 4'd4;
  localparam logic [3:0] C_BST  = 4'd5;
  localparam logic [3:0] C_PRE  = 4'd6;
  localparam logic [3:0] C_AREF = 4'd7;
  localparam logic [3:0] C_SREF = 4'd8;
  localparam logic [3:0] C_MRS  = 4'd9;

  logic [3:0]    cmd;
  logic [3:0]    bl;
  logic [2:0]    err_nx;
  logic [MW-1:0] mrd_cnt;

  always_comb begin
    if (cs_n) cmd = C_INH;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = C_NOP;
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b110:  cmd = C_BST;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = cke ? C_AREF : C_SREF;
        default: cmd = C_MRS;
      endcase
    end
  end

  wire is_act  = (cmd == C_ACT);
  wire is_rw   = (cmd == C_RD) || (cmd == C_WR);
  wire is_pre  = (cmd == C_PRE);
  wire is_ref  = (cmd == C_AREF) || (cmd == C_SREF);
  wire is_mrs  = (cmd == C_MRS);
  wire is_exec = (cmd != C_INH) && (cmd != C_NOP);
  wire any_act = |bank_active;
  wire ba_act  = bank_active[ba];

  always_comb begin
    case (mode_reg[2:0])
      3'd1:    bl = 4'd2;
      3'd2:    bl = 4'd4;
      3'd3:    bl = 4'd8;
      default: bl = 4'd1;
    endcase
    if (cmd == C_WR && mode_reg[9]) bl = 4'd1;
  end

  always_comb begin
    err_nx = 3'd0;
    if (is_exec && mrd_cnt != '0)  err_nx = 3'd2;
    else if (is_mrs && any_act)    err_nx = 3'd1;
    else if (is_rw && !ba_act)     err_nx = 3'd3;
    else if (is_act && ba_act)     err_nx = 3'd4;
    else if (is_ref && any_act)    err_nx = 3'd5;
  end

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic          act_r;
    logic [3:0]    ap_cnt;
    logic [AW-1:0] row_r;
    wire hit = (ba == BW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_r  <= 1'b0;
        ap_cnt <= '0;
        row_r  <= '0;
      end else if (is_act && hit) begin
        act_r  <= 1'b1;
        ap_cnt <= '0;
        row_r  <= addr;
      end else if (is_pre && (addr[AP_BIT] || hit)) begin
        act_r  <= 1'b0;
        ap_cnt <= '0;
      end else if (is_rw && hit && addr[AP_BIT]) begin
        ap_cnt <= bl;
      end else if (ap_cnt != '0) begin
        ap_cnt <= ap_cnt - 4'd1;
        if (ap_cnt == 4'd1) act_r <= 1'b0;
      end
    end

    assign bank_active[g]         = act_r;
    assign open_row[g*AW +: AW]   = row_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_code     <= C_INH;
      mode_reg     <= '0;
      mrd_cnt      <= '0;
      self_refresh <= 1'b0;
      ref_count    <= '0;
      err_pulse    <= 1'b0;
      err_code     <= 3'd0;
      err_seen     <= '0;
    end else begin
      cmd_code <= cmd;
      if (is_mrs) begin
        mode_reg <= addr;
        mrd_cnt  <= MW'(TMRD - 1);
      end else if (mrd_cnt != '0) begin
        mrd_cnt  <= mrd_cnt - 1'b1;
      end
      if (cmd == C_SREF)    self_refresh <= 1'b1;
      else if (cke)         self_refresh <= 1'b0;
      if (cmd == C_AREF)    ref_count <= ref_count + 1'b1;
      err_pulse <= (err_nx != 3'd0);
      err_code  <= err_nx;
      if (err_nx != 3'd0) err_seen <= err_seen | (5'd1 << (err_nx - 3'd1));
    end
  end

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int NB     = 4,
  parameter int AW     = 12,
  parameter int AP_BIT = 10,
  localparam int BW    = (NB > 1) ? $clog2(NB) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [BW-1:0]    ba,
  input logic [AW-1:0]    addr,
  input logic [NB-1:0]    bank_active,
  input logic [NB*AW-1:0] open_row,
  input logic [AW-1:0]    mode_reg,
  input logic             err_pulse,
  input logic [2:0]       err_code,
  input logic [4:0]       err_seen
);

  wire b_act = !cs_n && !ras_n &&  cas_n &&  we_n;
  wire b_rw  = !cs_n &&  ras_n && !cas_n;
  wire b_pre = !cs_n && !ras_n &&  cas_n && !we_n;
  wire b_mrs = !cs_n && !ras_n && !cas_n && !we_n;
  wire b_sel_act = ((bank_active >> ba) & NB'(1)) != '0;

  a_r10_pulse_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_code != 3'd0));

  a_r10_quiet_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse |-> (err_code == 3'd0));

  a_r10_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_seen & $past(err_seen)) == $past(err_seen)));

  a_r1_inhibit_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(open_row) && $stable(mode_reg)));

  a_r2_act_opens_bank: assert property (@(posedge clk) disable iff (!rst_n)
    b_act |=> (((bank_active >> $past(ba)) & NB'(1)) != '0));

  a_r3_prea_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
    (b_pre && addr[AP_BIT]) |=> (bank_active == '0));

  a_r5_mrs_busy_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (b_mrs && (bank_active != '0)) |=> err_pulse);

  a_r7_rw_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (b_rw && !b_sel_act) |=> err_pulse);

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.NB(NB), .AW(AW), .AP_BIT(AP_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .ba(ba), .addr(addr), .bank_active(bank_active), .open_row(open_row),
  .mode_reg(mode_reg), .err_pulse(err_pulse), .err_code(err_code), .err_seen(err_seen)
);

// File: tb/test_sdram_cmd_monitor.sv
module test_sdram_cmd_monitor;
  localparam int NB = 4, AW = 12;
  localparam logic [3:0] INH = 0, NOP = 1, ACT = 2, RD = 3, WR = 4, PRE = 6, AREF = 7, SREF = 8, MRS = 9;

  logic clk = 0, rst_n = 0, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0] ba = 0;
  logic [AW-1:0] addr = 0;
  logic [3:0] cmd_code;
  logic [NB-1:0] bank_active;
  logic [NB*AW-1:0] open_row;
  logic [AW-1:0] mode_reg;
  logic self_refresh;
  logic [15:0] ref_count;
  logic err_pulse;
  logic [2:0] err_code;
  logic [4:0] err_seen;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_cmd_monitor i_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_code(cmd_code), .bank_active(bank_active),
    .open_row(open_row), .mode_reg(mode_reg), .self_refresh(self_refresh),
    .ref_count(ref_count), .err_pulse(err_pulse), .err_code(err_code), .err_seen(err_seen)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic [AW-1:0] a, input bit k = 1);
    cs_n = 0; cke = k; ba = b; addr = a;
    case (c)
      INH:     begin cs_n = 1; {ras_n, cas_n, we_n} = 3'b000; end
      ACT:     {ras_n, cas_n, we_n} = 3'b011;
      RD:      {ras_n, cas_n, we_n} = 3'b101;
      WR:      {ras_n, cas_n, we_n} = 3'b100;
      PRE:     {ras_n, cas_n, we_n} = 3'b010;
      AREF:    {ras_n, cas_n, we_n} = 3'b001;
      MRS:     {ras_n, cas_n, we_n} = 3'b000;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
    @(negedge clk);
    cs_n = 0; cke = 1; {ras_n, cas_n, we_n} = 3'b111;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 banks idle", bank_active, 0);
    chk("R11 rows zero", open_row, 0);
    chk("R11 mode zero", mode_reg, 0);
    chk("R11 cmd zero", cmd_code, 0);
    chk("R11 ref_count zero", ref_count, 0);
    chk("R11 err clear", {self_refresh, err_pulse, err_code, err_seen}, 0);
  endtask

  task automatic t_mode;
    issue(MRS, 0, 12'h022);
    chk("R5 mode captured", mode_reg, 12'h022);
    chk("R1 mrs decode", cmd_code, MRS);
    chk("R5 idle mrs no error", err_pulse, 0);
    nop(1);
    issue(ACT, 0, 12'h011);
    chk("R6 after window no error", err_pulse, 0);
    issue(MRS, 0, 12'h033);
    chk("R5 mrs busy code", {err_pulse, err_code}, {1'b1, 3'd1});
    chk("R5 mode still captured", mode_reg, 12'h033);
    nop(1);
    chk("R10 pulse one cycle", {err_pulse, err_code}, 0);
    issue(PRE, 0, 12'h400);
  endtask

  task automatic t_inhibit;
    issue(ACT, 1, 12'h155);
    issue(INH, 2, 12'h7AA);
    chk("R1 inhibit decode", cmd_code, INH);
    chk("R1 inhibit keeps mode", mode_reg, 12'h033);
    chk("R1 inhibit keeps banks", bank_active, 4'b0010);
    chk("R1 inhibit keeps row", open_row[1*AW +: AW], 12'h155);
    chk("R1 inhibit no error", err_pulse, 0);
    issue(PRE, 0, 12'h400);
  endtask

  task automatic t_tmrd;
    issue(MRS, 0, 12'h002);
    issue(ACT, 0, 12'h001);
    chk("R6 window violation code", {err_pulse, err_code}, {1'b1, 3'd2});
    chk("R6 command still applied", bank_active, 4'b0001);
    issue(PRE, 0, 12'h400);
    issue(MRS, 0, 12'h002);
    nop(1);
    issue(ACT, 0, 12'h001);
    chk("R6 boundary legal", err_pulse, 0);
    issue(PRE, 0, 12'h400);
  endtask

  task automatic t_act_pre;
    issue(ACT, 2, 12'hABC);
    chk("R2 bank2 active", bank_active, 4'b0100);
    chk("R2 bank2 row", open_row[2*AW +: AW], 12'hABC);
    chk("R1 act decode", cmd_code, ACT);
    issue(ACT, 3, 12'h123);
    issue(PRE, 2, 12'h000);
    chk("R3 single precharge", bank_active, 4'b1000);
    issue(ACT, 0, 12'h010);
    issue(PRE, 1, 12'h400);
    chk("R3 precharge all ignores ba", bank_active, 4'b0000);
    chk("R3 no error", err_pulse, 0);
  endtask

  task automatic t_rw_idle;
    issue(RD, 1, 12'h005);
    chk("R7 read idle code", {err_pulse, err_code}, {1'b1, 3'd3});
    issue(WR, 2, 12'h006);
    chk("R7 write idle code", {err_pulse, err_code}, {1'b1, 3'd3});
    issue(ACT, 1, 12'h020);
    issue(RD, 1, 12'h005);
    chk("R7 read open legal", err_pulse, 0);
    chk("R7 plain read keeps bank", bank_active, 4'b0010);
    issue(PRE, 0, 12'h400);
  endtask

  task automatic t_act_active;
    issue(ACT, 3, 12'h0F0);
    issue(ACT, 3, 12'h0F1);
    chk("R8 double activate code", {err_pulse, err_code}, {1'b1, 3'd4});
    issue(PRE, 0, 12'h400);
  endtask

  task automatic t_autopre;
    issue(MRS, 0, 12'h002);
    nop(1);
    issue(ACT, 1, 12'h040);
    issue(RD, 1, 12'h400);
    nop(3);
    chk("R4 bl4 still open", bank_active, 4'b0010);
    nop(1);
    chk("R4 bl4 closed", bank_active, 4'b0000);
    issue(MRS, 0, 12'h202);
    nop(1);
    issue(ACT, 1, 12'h041);
    issue(WR, 1, 12'h400);
    chk("R4 write single open", bank_active, 4'b0010);
    nop(1);
    chk("R4 write single closed", bank_active, 4'b0000);
  endtask

  task automatic t_refresh;
    logic [15:0] rc;
    issue(ACT, 0, 12'h001);
    issue(AREF, 0, 12'h000);
    chk("R9 refresh busy code", {err_pulse, err_code}, {1'b1, 3'd5});
    issue(PRE, 0, 12'h400);
    rc = ref_count;
    issue(AREF, 0, 12'h000);
    chk("R9 auto refresh count", ref_count, rc + 16'd1);
    chk("R1 auto refresh decode", cmd_code, AREF);
    chk("R9 idle refresh legal", err_pulse, 0);
    issue(AREF, 0, 12'h000, 0);
    cs_n = 1; cke = 0;
    chk("R1 self refresh decode", cmd_code, SREF);
    chk("R9 self refresh set", self_refresh, 1);
    chk("R9 self refresh not counted", ref_count, rc + 16'd1);
    nop(1);
    chk("R9 self refresh held", self_refresh, 1);
    cke = 1;
    nop(1);
    chk("R9 self refresh exit", self_refresh, 0);
    cs_n = 0;
  endtask

  task automatic t_sticky;
    nop(1);
    chk("R10 sticky all codes", err_seen, 5'h1F);
    chk("R10 quiet code zero", {err_pulse, err_code}, 0);
    rst_n = 0;
    nop(2);
    rst_n = 1;
    chk("R10 sticky cleared by reset", err_seen, 0);
  endtask

  initial begin
    nop(3);
    rst_n = 1;
    nop(1);
    t_reset();
    t_mode();
    t_inhibit();
    t_tmrd();
    t_act_pre();
    t_rw_idle();
    t_act_active();
    t_autopre();
    t_refresh();
    t_sticky();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule